// File: doc/BRIEF.md
# Peak-Current Phase-Shifted Full-Bridge PWM Generator

This block drives the four primary switches of a phase-shifted full bridge that runs under peak current mode control. One up-down counter sets the switching period. The counter's two turning points, the zero point and the peak point, divide each period into an up half and a down half. The fixed leg toggles at each turning point. Its two gates are complementary, run at 50 % duty, and are separated by a programmable dead time.

The phase of the controlled leg is never programmed. An external comparator, which is not part of this block, asserts a synchronous trip input when the transformer current reaches its peak reference. The first trip in a half cycle that is not masked ends the conduction of the active controlled gate at once. The complementary controlled gate turns on only after a separate dead time for the active-to-passive transition. If no trip arrives, the controlled leg switches at the turning point, which gives the largest overlap between diagonal switches. A leading-edge blanking window, placed relative to each turning point, hides the switching noise that follows a transition. The same trip path and the same rules apply to both halves, so the two halves stay symmetrical.

The diagonal pairs are the fixed A gate with the controlled B gate, and the fixed B gate with the controlled A gate. The period and both dead times are sampled only at the zero point, so a new command never splits a period.

Top module: `psfb_pcmc_pwm`

## Requirements
- R1: The counter period is 2*`period` clock cycles. `zero_stb` pulses once per period, and `peak_stb` pulses exactly `period` cycles after each `zero_stb`. The two strobes are never high in the same cycle.
- R2: `fix_a` is high for `period - dt_fixed` cycles in the up half and `fix_b` for the same number of cycles in the down half. The two are never high together.
- R3: With no trip, `ctl_b` is high for `period - dt_ctrl` cycles in the up half and `ctl_a` for the same number in the down half. `ctl_a` and `ctl_b` are never high together.
- R4: A trip taken at half-cycle position e of the up half (e counts cycles from the zero point, which is position 0) drops `ctl_b` two clocks later, so its pulse is `e - dt_ctrl` cycles long. `ctl_a` rises `dt_ctrl` cycles after that.
- R5: A trip taken at position e of the down half (counted from the peak point) drops `ctl_a` two clocks later. Its pulse then lasts from its rise until that drop.
- R6: Only the first effective trip in a half cycle acts. Later trips in the same half change no output.
- R7: A trip at a half-cycle position p with `blank_off <= p < blank_off + blank_len` is ignored, and a later unmasked trip in the same half still acts.
- R8: A new `period` or dead-time value applied in mid-period takes effect only from the next zero point.
- R9: While `en` is low, all four gates and both strobes are low from the next cycle on and the counter is held at zero. The first enabled cycle is a zero point, and `zero_stb` follows one clock later.
- R10: While `rst` is high, all outputs are low. The first cycle after reset with `en` high is a zero point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces the outputs low |
| period | input | CW | Half-period length in cycles (at least 2) |
| dt_fixed | input | DW | Dead time of the fixed leg |
| dt_ctrl | input | DW | Active-to-passive dead time of the controlled leg |
| blank_off | input | CW | Start of the blanking window from the turning point |
| blank_len | input | CW | Length of the blanking window |
| trip | input | 1 | Synchronous peak-current trip |
| fix_a | output | 1 | Fixed leg, upper gate |
| fix_b | output | 1 | Fixed leg, lower gate |
| ctl_a | output | 1 | Controlled leg, upper gate |
| ctl_b | output | 1 | Controlled leg, lower gate |
| zero_stb | output | 1 | Zero-point strobe, one clock after the event |
| peak_stb | output | 1 | Peak-point strobe, one clock after the event |

## Verification
The assertions assume that `period` is at least 2 and that `trip` is already synchronous to `clk`. They make no assumption about the dead times or the blanking window. These only change pulse widths, and the exclusion and strobe properties hold for any value. The stimulus keeps each dead time shorter than every pulse it shapes. It lays each blanking window inside one half cycle and times each single-cycle trip from the observed zero strobe, so every trip lands on a known half-cycle position. Each case with trips is preceded by an idle period, so the controlled leg always starts that case from its default state.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  // Which slope of the up-down counter is running
  typedef enum logic {
    HALF_DN = 1'b0,
    HALF_UP = 1'b1
  } half_e;
endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CW-1:0]     period,
  input  logic [DW-1:0]     dt_fixed,
  input  logic [DW-1:0]     dt_ctrl,
  output psfb_pkg::half_e   half,
  output logic [CW-1:0]     elapsed,
  output logic              zero_ev,
  output logic              peak_ev,
  output logic [DW-1:0]     dtf_q,
  output logic [DW-1:0]     dtc_q
);
  import psfb_pkg::*;

  logic [CW-1:0] cnt;
  logic [CW-1:0] prd_q;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      half  <= HALF_UP;
      prd_q <= period;
      dtf_q <= dt_fixed;
      dtc_q <= dt_ctrl;
    end else begin
      if (cnt == '0) begin
        prd_q <= period;
        dtf_q <= dt_fixed;
        dtc_q <= dt_ctrl;
      end
      if (half == HALF_UP) begin
        cnt <= cnt_inc;
        if (cnt_inc == prd_q) half <= HALF_DN;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) half <= HALF_UP;
      end
    end
  end

  // Cycles since the last turning point; 0 on the turning point itself
  assign elapsed = (half == HALF_UP) ? cnt : (prd_q - cnt);
  assign zero_ev = (half == HALF_UP) && (cnt == '0);
  assign peak_ev = (half == HALF_DN) && (cnt == prd_q);
endmodule

// File: rtl/psfb_trip_leg.sv
module psfb_trip_leg #(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  psfb_pkg::half_e half,
  input  logic [CW-1:0]   elapsed,
  input  logic [CW-1:0]   blank_off,
  input  logic [CW-1:0]   blank_len,
  input  logic            trip,
  output logic            aq
);
  import psfb_pkg::*;

  localparam int EW = CW + 1;

  logic [EW-1:0] win_end;
  logic          masked;
  logic          take;

  assign win_end = {1'b0, blank_off} + {1'b0, blank_len};
  assign masked  = (elapsed >= blank_off) && ({1'b0, elapsed} < win_end);
  assign take    = trip && !masked;

  // Turning point sets the default level; a taken trip flips it early.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      aq <= 1'b0;
    end else if (elapsed == '0) begin
      aq <= (half == HALF_DN);
    end else if (take) begin
      aq <= (half == HALF_UP);
    end
  end
endmodule

// File: rtl/psfb_deadband.sv
module psfb_deadband #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          raw,
  input  logic [DW-1:0] dt,
  output logic          out_a,
  output logic          out_b
);
  localparam int AW = DW + 1;

  logic          prev;
  logic [DW-1:0] run;
  logic [AW-1:0] age;
  logic          aged;

  // age: number of earlier cycles the raw level has already held
  assign age  = (raw == prev) ? ({1'b0, run} + 1'b1) : '0;
  assign aged = (age >= {1'b0, dt});

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b0;
      run   <= '1;
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else begin
      prev  <= raw;
      run   <= age[DW] ? '1 : age[DW-1:0];
      out_a <= en && raw && aged;
      out_b <= en && !raw && aged;
    end
  end
endmodule

// File: rtl/psfb_pcmc_pwm.sv
module psfb_pcmc_pwm #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] period,
  input  logic [DW-1:0] dt_fixed,
  input  logic [DW-1:0] dt_ctrl,
  input  logic [CW-1:0] blank_off,
  input  logic [CW-1:0] blank_len,
  input  logic          trip,
  output logic          fix_a,
  output logic          fix_b,
  output logic          ctl_a,
  output logic          ctl_b,
  output logic          zero_stb,
  output logic          peak_stb
);
  import psfb_pkg::*;

  localparam int NLEG = 2;

  half_e         half;
  logic [CW-1:0] elapsed;
  logic          zero_ev;
  logic          peak_ev;
  logic [DW-1:0] dtf_q;
  logic [DW-1:0] dtc_q;
  logic          aq;
  logic          raw_fix;

  psfb_timebase #(.CW(CW), .DW(DW)) u_tbase (
    .clk(clk), .rst(rst), .en(en),
    .period(period), .dt_fixed(dt_fixed), .dt_ctrl(dt_ctrl),
    .half(half), .elapsed(elapsed), .zero_ev(zero_ev), .peak_ev(peak_ev),
    .dtf_q(dtf_q), .dtc_q(dtc_q)
  );

  psfb_trip_leg #(.CW(CW)) u_trip (
    .clk(clk), .rst(rst), .en(en),
    .half(half), .elapsed(elapsed),
    .blank_off(blank_off), .blank_len(blank_len),
    .trip(trip), .aq(aq)
  );

  // Fixed-leg level is registered so both legs share one cycle of latency
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_fix  <= 1'b0;
      zero_stb <= 1'b0;
      peak_stb <= 1'b0;
    end else begin
      raw_fix  <= en && (half == HALF_UP);
      zero_stb <= en && zero_ev;
      peak_stb <= en && peak_ev;
    end
  end

  logic [NLEG-1:0] leg_raw;
  logic [DW-1:0]   leg_dt [NLEG];
  logic [NLEG-1:0] leg_a;
  logic [NLEG-1:0] leg_b;

  assign leg_raw   = {aq, raw_fix};
  assign leg_dt[0] = dtf_q;
  assign leg_dt[1] = dtc_q;

  generate
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
      psfb_deadband #(.DW(DW)) u_db (
        .clk(clk), .rst(rst), .en(en),
        .raw(leg_raw[g]), .dt(leg_dt[g]),
        .out_a(leg_a[g]), .out_b(leg_b[g])
      );
    end
  endgenerate

  assign fix_a = leg_a[0];
  assign fix_b = leg_b[0];
  assign ctl_a = leg_a[1];
  assign ctl_b = leg_b[1];
endmodule

// File: rtl/psfb_pcmc_pwm_chk.sv
module psfb_pcmc_pwm_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic fix_a,
  input logic fix_b,
  input logic ctl_a,
  input logic ctl_b,
  input logic zero_stb,
  input logic peak_stb
);
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(zero_stb && peak_stb)); // R1

  AST_FIXED_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fix_a && fix_b)); // R2

  AST_CTRL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ctl_a && ctl_b)); // R3

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !(fix_a || fix_b || ctl_a || ctl_b || zero_stb || peak_stb)); // R9

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    zero_stb |=> !zero_stb); // R1
endmodule

bind psfb_pcmc_pwm psfb_pcmc_pwm_chk u_chk (
  .clk(clk), .rst(rst), .en(en),
  .fix_a(fix_a), .fix_b(fix_b), .ctl_a(ctl_a), .ctl_b(ctl_b),
  .zero_stb(zero_stb), .peak_stb(peak_stb)
);

// File: tb/psfb_pcmc_pwm_test.sv
module psfb_pcmc_pwm_test;
  localparam int CLK_NS = 10;
  localparam int CW = 8;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b1;
  logic          trip = 1'b0;
  logic [CW-1:0] prd = 8'd10;
  logic [DW-1:0] dtf = 4'd3;
  logic [DW-1:0] dtc = 4'd2;
  logic [CW-1:0] boff = 8'd0;
  logic [CW-1:0] blen = 8'd3;
  logic fa, fb, ca, cb, zs, ps;

  psfb_pcmc_pwm #(.CW(CW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .en(en), .period(prd), .dt_fixed(dtf), .dt_ctrl(dtc),
    .blank_off(boff), .blank_len(blen), .trip(trip),
    .fix_a(fa), .fix_b(fb), .ctl_a(ca), .ctl_b(cb), .zero_stb(zs), .peak_stb(ps)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cur = 0;
  // pulse-width monitor: index 0 fix_a, 1 fix_b, 2 ctl_a, 3 ctl_b
  int run_w [4] = '{0, 0, 0, 0};
  int wid   [4] = '{0, 0, 0, 0};
  int since_z = 0;
  int zint = 0;
  int zpos = 0;

  always @(negedge clk) begin
    logic [3:0] o;
    o = {cb, ca, fb, fa};
    for (int i = 0; i < 4; i++) begin
      if (o[i]) run_w[i]++;
      else if (run_w[i] > 0) begin
        wid[i] = run_w[i];
        run_w[i] = 0;
      end
    end
    if (zs) begin
      zint = since_z + 1;
      since_z = 0;
    end else begin
      since_z++;
      if (ps) zpos = since_z;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  function automatic bit masked(input int e);
    return (e >= int'(boff)) && (e < int'(boff) + int'(blen));
  endfunction

  // first effective trip position in a half, or the full half if none
  function automatic int eff(input int e1, input int e2);
    if (e1 > 0 && !masked(e1)) return e1;
    if (e2 > 0 && !masked(e2)) return e2;
    return int'(prd);
  endfunction

  task automatic wait_zero();
    @(negedge clk);
    while (!zs) @(negedge clk);
    cur = 0;
  endtask

  // cycle index t relative to the zero strobe cycle s; state of cycle s-1+p has position p
  task automatic trip_at(input int t);
    repeat (t - cur) @(negedge clk);
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    cur = t + 1;
  endtask

  task automatic wait_to(input int t);
    repeat (t - cur) @(negedge clk);
    cur = t;
  endtask

  task automatic run_case(input int u1, input int u2, input int d1, input int d2, input string rq);
    int eu, ed;
    wait_zero();
    if (u1 > 0) trip_at(u1 - 1);
    if (u2 > 0) trip_at(u2 - 1);
    if (d1 > 0) trip_at(int'(prd) + d1 - 1);
    if (d2 > 0) trip_at(int'(prd) + d2 - 1);
    wait_to(2 * int'(prd) + 2);
    #1;
    eu = eff(u1, u2);
    ed = eff(d1, d2);
    chk(rq, wid[3], eu - int'(dtc));
    chk(rq, wid[2], int'(prd) + ed - eu - int'(dtc));
    chk("R2", wid[0], int'(prd) - int'(dtf));
    chk("R2", wid[1], int'(prd) - int'(dtf));
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    int quiet;
    // R10: outputs low in reset even with en high
    repeat (4) @(negedge clk);
    chk("R10", int'({fa, fb, ca, cb, zs, ps}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", int'(zs), 1);

    // two idle periods so the controlled leg starts from its default
    wait_zero();
    wait_zero();

    run_case(0, 0, 0, 0, "R3");
    for (int e = 1; e < 10; e++) run_case(e, 0, 0, 0, masked(e) ? "R7" : "R4");
    for (int e = 1; e < 10; e++) run_case(0, 0, e, 0, masked(e) ? "R7" : "R5");
    run_case(4, 0, 6, 0, "R4");
    run_case(3, 6, 0, 0, "R6");
    run_case(0, 0, 4, 5, "R6");
    run_case(5, 8, 3, 9, "R6");
    run_case(1, 5, 2, 7, "R7");

    // second blanking window placed away from the turning point
    boff = 8'd5;
    blen = 8'd2;
    run_case(5, 0, 0, 0, "R7");
    run_case(6, 0, 0, 0, "R7");
    run_case(7, 0, 0, 0, "R4");
    run_case(0, 0, 5, 0, "R7");
    run_case(0, 0, 6, 9, "R7");
    run_case(0, 0, 7, 0, "R5");

    chk("R1", zint, 2 * int'(prd));
    chk("R1", zpos, int'(prd));

    // R8: period changed mid-period applies from the next zero point
    wait_zero();
    prd = 8'd8;
    wait_zero();
    #1;
    chk("R8", zint, 20);
    wait_zero();
    #1;
    chk("R8", zint, 16);
    chk("R1", zpos, 8);

    // R8: controlled dead time changed mid-period
    wait_zero();
    dtc = 4'd3;
    wait_to(2 * int'(prd) + 2);
    #1;
    chk("R8", wid[2], 8 - 2);
    wait_zero();
    wait_to(2);
    #1;
    chk("R8", wid[2], 8 - 3);

    // R9: disable forces everything low, restart begins at a zero point
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    quiet = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if ({fa, fb, ca, cb, zs, ps} != 6'b0) quiet++;
    end
    chk("R9", quiet, 0);
    en = 1'b1;
    @(negedge clk);
    chk("R9", int'(zs), 1);
    wait_zero();
    #1;
    chk("R9", zint, 16);

    summary();
    $finish;
  end
endmodule